// File: doc/BRIEF.md
# Serial Frame Header Decoder

This block sits on a continuously clocked serial link that carries one data line and one load strobe. Both are sampled on the rising clock edge. While the strobe is low the block hunts for an 8-bit synchronisation word, most significant bit first. Once the word is found, the strobe must rise close to the first command bit. The block then takes in a 16-bit header body: a 2-bit command sent three times, followed by a 10-bit fault counter field.

A header is accepted when the strobe timing is right and all three command copies agree. On acceptance the block raises a frame-active flag and publishes the command, the fault-type select and the counter value. The flag stays up for as long as the strobe remains high. If the copies disagree, the block raises an error flag instead, and the header's fields are discarded. A low strobe at any point ends or aborts the frame and sends the block back to hunting.

Top module: `frame_hdr_decoder`

## Requirements
- R1: During and right after the synchronous active-low reset, `frameActive` and `cmdErr` are 0, and `cmdCode` and `faultCount` are 0.
- R2: The sync word 8'hE8 is recognised MSB first only while the strobe is low on the sample before the last sync bit. After a valid header, `frameActive` reads 1 right after the clock edge that samples counter bit b0. A stream with any other 8-bit word (for example 8'hE9) raises no flag.
- R3: The strobe may go from low to high on the last sync bit, on the first command bit or on the second command bit, and the header is then accepted. If it is still low on the second command bit, the header is dropped: no flag rises, and `cmdCode` and `faultCount` keep their old values.
- R4: The command pair C1,C0 is sent three times. When the copies agree, `cmdCode` = {C1,C0}. The codes are 00 per-output PWM load, 01 calibration DAC load, 10 global-intensity load and 11 configuration load.
- R5: `faultOpen` equals C0 of the accepted command: 1 selects open-LED faults and 0 selects overtemperature faults.
- R6: The 10 counter bits following the command bits are received b9 first. They appear on `faultCount` when the header is accepted.
- R7: If any command copy differs from the others, `cmdErr` reads 1 and `frameActive` stays 0 at the header end. `cmdCode` and `faultCount` keep their previous values.
- R8: A low strobe once the strobe has risen aborts the header with no flag raised. In an active or errored frame, a low strobe clears both flags on the next edge.
- R9: `frameActive` and `cmdErr` are never 1 together, and neither rises unless the strobe was high on the edge that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; inputs sampled on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| serIn | input | 1 | Serial data line |
| loadIn | input | 1 | Load strobe |
| frameActive | output | 1 | Accepted header, frame in progress |
| cmdErr | output | 1 | Command copies disagreed in the current frame |
| cmdCode | output | 2 | Last accepted command {C1,C0} |
| faultOpen | output | 1 | Fault type selected by the last accepted command (1 open LED) |
| faultCount | output | 10 | Last accepted counter field |

## Verification
The assertions assume that `loadIn` and `serIn` change only away from the rising edge. They also assume that the strobe is low when each header is searched for, so the flags start from their cleared state before a new header. The bench drives both lines on the falling edge and keeps the strobe low through idle gaps and sync words, except in the early-rise case. It ends every frame with at least one low-strobe cycle. Counter and command values are chosen so that no stretch of a dropped header, once it is searched again, forms the sync word by accident.

// File: rtl/frame_hdr_pkg.sv
package frame_hdr_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_HEADER,
    ST_ACTIVE,
    ST_REJECT
  } hdrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftSync;
    logic clearSync;
    logic startHdr;
    logic shiftHdr;
    logic capture;
    logic setErr;
    logic clrFlags;
  } ctlStrobe_t;

endpackage

// File: rtl/frame_hdr_dpath.sv
module frame_hdr_dpath
  import frame_hdr_pkg::*;
#(
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hE8,
  parameter int CMD_W = 2,
  parameter int CMD_REPS = 3,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             loadIn,
  input  ctlStrobe_t       ctl,
  output logic             syncHit,
  output logic             secondBit,
  output logic             lastBit,
  output logic             cmdOk,
  output logic             frameActive,
  output logic             cmdErr,
  output logic [CMD_W-1:0] cmdCode,
  output logic [CNT_W-1:0] faultCount
);

  localparam int CMDF_W = CMD_W * CMD_REPS;
  localparam int HDR_W  = CMDF_W + CNT_W;
  localparam int IDX_W  = $clog2(HDR_W);

  logic [SYNC_W-2:0] syncSh;
  logic              loadPrev;
  logic [HDR_W-2:0]  hdrSh;
  logic [IDX_W-1:0]  bitIdx;
  logic [HDR_W-1:0]  hdrFull;
  logic [CMDF_W-1:0] cmdField;
  logic [CMD_REPS-1:0] copyEq;

  assign hdrFull  = {hdrSh, serIn};
  assign cmdField = hdrFull[HDR_W-1 -: CMDF_W];

  assign copyEq[0] = 1'b1;
  for (genvar r = 1; r < CMD_REPS; r++) begin : g_copy
    assign copyEq[r] = (cmdField[r*CMD_W +: CMD_W] == cmdField[0 +: CMD_W]);
  end

  assign cmdOk     = &copyEq;
  assign syncHit   = ({syncSh, serIn} == SYNC_WORD) && !loadPrev;
  assign secondBit = (bitIdx == IDX_W'(1));
  assign lastBit   = (bitIdx == IDX_W'(HDR_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncSh   <= '0;
      loadPrev <= 1'b0;
      hdrSh    <= '0;
      bitIdx   <= '0;
    end else begin
      loadPrev <= loadIn;
      if (ctl.clearSync)      syncSh <= '0;
      else if (ctl.shiftSync) syncSh <= {syncSh[SYNC_W-3:0], serIn};
      if (ctl.shiftHdr)       hdrSh  <= hdrFull[HDR_W-2:0];
      if (ctl.startHdr)       bitIdx <= '0;
      else if (ctl.shiftHdr)  bitIdx <= bitIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      cmdErr      <= 1'b0;
      cmdCode     <= '0;
      faultCount  <= '0;
    end else begin
      if (ctl.clrFlags) begin
        frameActive <= 1'b0;
        cmdErr      <= 1'b0;
      end else begin
        if (ctl.capture) frameActive <= 1'b1;
        if (ctl.setErr)  cmdErr      <= 1'b1;
      end
      if (ctl.capture) begin
        cmdCode    <= cmdField[CMD_W-1:0];
        faultCount <= hdrFull[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/frame_hdr_ctrl.sv
module frame_hdr_ctrl
  import frame_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadIn,
  input  logic       syncHit,
  input  logic       secondBit,
  input  logic       lastBit,
  input  logic       cmdOk,
  output ctlStrobe_t ctl
);

  hdrState_e stateQ, stateNxt;
  logic      riseSeen, riseNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = stateQ;
    riseNxt  = riseSeen;
    unique case (stateQ)
      ST_SEARCH: begin
        ctl.shiftSync = 1'b1;
        if (syncHit) begin
          stateNxt     = ST_HEADER;
          ctl.startHdr = 1'b1;
          riseNxt      = loadIn;
        end
      end
      ST_HEADER: begin
        ctl.clearSync = 1'b1;
        if (!loadIn && (riseSeen || secondBit)) begin
          stateNxt = ST_SEARCH;
        end else begin
          ctl.shiftHdr = 1'b1;
          riseNxt      = riseSeen | loadIn;
          if (lastBit) begin
            if (cmdOk) begin
              ctl.capture = 1'b1;
              stateNxt    = ST_ACTIVE;
            end else begin
              ctl.setErr = 1'b1;
              stateNxt   = ST_REJECT;
            end
          end
        end
      end
      ST_ACTIVE, ST_REJECT: begin
        ctl.clearSync = 1'b1;
        if (!loadIn) begin
          ctl.clrFlags = 1'b1;
          stateNxt     = ST_SEARCH;
        end
      end
      default: stateNxt = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_SEARCH;
      riseSeen <= 1'b0;
    end else begin
      stateQ   <= stateNxt;
      riseSeen <= riseNxt;
    end
  end

endmodule

// File: rtl/frame_hdr_decoder.sv
module frame_hdr_decoder
  import frame_hdr_pkg::*;
#(
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hE8,
  parameter int CMD_W = 2,
  parameter int CMD_REPS = 3,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             loadIn,
  output logic             frameActive,
  output logic             cmdErr,
  output logic [CMD_W-1:0] cmdCode,
  output logic             faultOpen,
  output logic [CNT_W-1:0] faultCount
);

  ctlStrobe_t ctl;
  logic       syncHit, secondBit, lastBit, cmdOk;

  frame_hdr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadIn    (loadIn),
    .syncHit   (syncHit),
    .secondBit (secondBit),
    .lastBit   (lastBit),
    .cmdOk     (cmdOk),
    .ctl       (ctl)
  );

  frame_hdr_dpath #(
    .SYNC_W    (SYNC_W),
    .SYNC_WORD (SYNC_WORD),
    .CMD_W     (CMD_W),
    .CMD_REPS  (CMD_REPS),
    .CNT_W     (CNT_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .serIn       (serIn),
    .loadIn      (loadIn),
    .ctl         (ctl),
    .syncHit     (syncHit),
    .secondBit   (secondBit),
    .lastBit     (lastBit),
    .cmdOk       (cmdOk),
    .frameActive (frameActive),
    .cmdErr      (cmdErr),
    .cmdCode     (cmdCode),
    .faultCount  (faultCount)
  );

  // fault type follows the low command bit
  assign faultOpen = cmdCode[0];

endmodule

// File: rtl/frame_hdr_checker.sv
module frame_hdr_checker #(
  parameter int CMD_W = 2,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadIn,
  input logic             frameActive,
  input logic             cmdErr,
  input logic [CMD_W-1:0] cmdCode,
  input logic [CNT_W-1:0] faultCount
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(frameActive && cmdErr)); // R9

  AST_LOW_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !loadIn |=> (!frameActive && !cmdErr)); // R8

  AST_ACTIVE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameActive) |-> $past(loadIn)); // R9

  AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdErr) |-> $past(loadIn)); // R7

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(frameActive) |-> ($stable(cmdCode) && $stable(faultCount))); // R6

endmodule

bind frame_hdr_decoder frame_hdr_checker #(
  .CMD_W (CMD_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .loadIn      (loadIn),
  .frameActive (frameActive),
  .cmdErr      (cmdErr),
  .cmdCode     (cmdCode),
  .faultCount  (faultCount)
);

// File: tb/frame_hdr_decoder_tb.sv
`timescale 1ns/1ps
module frame_hdr_decoder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serIn = 1'b0;
  logic       loadIn = 1'b0;
  logic       frameActive, cmdErr, faultOpen;
  logic [1:0] cmdCode;
  logic [9:0] faultCount;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  frame_hdr_decoder u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .serIn       (serIn),
    .loadIn      (loadIn),
    .frameActive (frameActive),
    .cmdErr      (cmdErr),
    .cmdCode     (cmdCode),
    .faultOpen   (faultOpen),
    .faultCount  (faultCount)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic ld);
    @(negedge clk);
    serIn  = b;
    loadIn = ld;
  endtask

  // riseAt: -1 last sync bit, 0.. header body bit index; dropAt: -1 never
  task automatic sendFrame(input logic [7:0] syncW, input logic [5:0] cmd,
                           input logic [9:0] cnt, input int riseAt, input int dropAt);
    repeat (3) drive(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive(syncW[7-i], (i == 7) && (riseAt < 0));
    for (int i = 0; i < 16; i++) begin
      logic b;
      logic ld;
      b  = (i < 6) ? cmd[5-i] : cnt[15-i];
      ld = (i >= riseAt) && !((dropAt >= 0) && (i >= dropAt));
      drive(b, ld);
    end
    @(negedge clk);
  endtask

  task automatic endFrame(input string tag);
    drive(1'b0, 1'b0);
    @(negedge clk);
    chk({tag, " R8 frameActive after strobe low"}, frameActive, 1'b0);
    chk({tag, " R8 cmdErr after strobe low"}, cmdErr, 1'b0);
  endtask

  task automatic testReset();
    chk("R1 frameActive", frameActive, 1'b0);
    chk("R1 cmdErr", cmdErr, 1'b0);
    chk("R1 cmdCode", cmdCode, 2'b00);
    chk("R1 faultCount", faultCount, 10'h000);
  endtask

  task automatic testGood(input string tag, input logic [1:0] c, input logic [9:0] cnt,
                          input int riseAt);
    sendFrame(8'hE8, {c, c, c}, cnt, riseAt, -1);
    chk({tag, " R2/R3 frameActive"}, frameActive, 1'b1);
    chk({tag, " R7 cmdErr"}, cmdErr, 1'b0);
    chk({tag, " R4 cmdCode"}, cmdCode, c);
    chk({tag, " R5 faultOpen"}, faultOpen, c[0]);
    chk({tag, " R6 faultCount"}, faultCount, cnt);
    @(negedge clk);
    chk({tag, " R2 frameActive holds"}, frameActive, 1'b1);
    endFrame(tag);
  endtask

  task automatic testDropped(input string tag, input logic [7:0] syncW, input logic [5:0] cmd,
                             input int riseAt, input int dropAt,
                             input logic [1:0] oldC, input logic [9:0] oldCnt);
    sendFrame(syncW, cmd, 10'h155, riseAt, dropAt);
    chk({tag, " frameActive"}, frameActive, 1'b0);
    chk({tag, " cmdErr"}, cmdErr, 1'b0);
    chk({tag, " cmdCode held"}, cmdCode, oldC);
    chk({tag, " faultCount held"}, faultCount, oldCnt);
    endFrame(tag);
  endtask

  task automatic testMismatch();
    sendFrame(8'hE8, 6'b011101, 10'h0C3, 0, -1);
    chk("R7 cmdErr", cmdErr, 1'b1);
    chk("R7 frameActive", frameActive, 1'b0);
    chk("R7 cmdCode held", cmdCode, 2'b11);
    chk("R7 faultCount held", faultCount, 10'h001);
    endFrame("R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGood("T01", 2'b01, 10'h2A5, 0);
    testGood("T10 early rise", 2'b10, 10'h3FF, -1);
    testGood("T11 late rise", 2'b11, 10'h001, 1);
    testDropped("R3 rise too late", 8'hE8, 6'b000000, 2, -1, 2'b11, 10'h001);
    testMismatch();
    testDropped("R8 abort mid header", 8'hE8, 6'b000000, 0, 8, 2'b11, 10'h001);
    testDropped("R2 wrong sync", 8'hE9, 6'b000000, 0, -1, 2'b11, 10'h001);
    testGood("T00", 2'b00, 10'h000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule